// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Update Sequencer

This block divides a 32768 Hz time base (a one-cycle `tick_en` strobe per input period) into a once-per-second update strobe. It raises an update-in-progress flag in a fixed window just before each update. It also derives a programmable periodic tick from the same counter chain. A small control register selects the divider state and the periodic rate. Software reads that register back with the live update-in-progress flag in its top bit.

The chain is one `DIV_W`-bit counter. While the divider field is in any non-run state, the counter is pinned at its midpoint. Restarting it therefore gives a first update half a second later. The periodic tick is taken from the low bits of the same counter, so changing the rate never moves its phase against the update. A separate `set_hold` input masks the update strobe and the update-in-progress flag. The counter keeps running underneath.

Every pin is plain control or status. The block has no data stream and no back-pressure.

Top module: `rtc_divchain_seq`

## Requirements
- R1: After reset, `rd_data` reads 0x70 (divider field 111, rate 0), and `update_o`, `uip_o` and `periodic_o` are low.
- R2: Control bits [6:4] are the divider field and bits [3:0] are the rate code. Only divider value 010 runs the chain. Any other value holds the counter at its midpoint, and no update, update-in-progress or periodic pulse occurs.
- R3: After the divider field is written to 010 from a held state, the first `update_o` pulse follows exactly 2^(DIV_W-1) counted ticks, which is 16384 by default. A tick counts only when `tick_en` is high.
- R4: While running, updates repeat every 2^DIV_W ticks. Rewriting the run value does not restart the chain.
- R5: `update_o` is a one-cycle pulse, visible in the cycle after the edge that counts the wrapping tick. `uip_o` is high for exactly the UIP_LEAD (8) ticks before it and low in the update cycle.
- R6: For rate codes 3 to 15, `periodic_o` pulses every 2^(code-1) ticks. Codes 1 and 2 give 128 and 256 ticks.
- R7: Rate code 0 produces no periodic pulse.
- R8: Periodic pulses fall at counter positions that are multiples of the period. With code 15 they come 16384 ticks after an update and again together with the next update.
- R9: While `set_hold` is high, neither `update_o` nor `uip_o` is asserted, but the chain keeps counting. After release, updates stay on the original 2^DIV_W grid.
- R10: `rd_data[7]` reflects `uip_o`. A write to bit 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe per time-base period |
| set_hold | input | 1 | Masks update strobe and UIP while high |
| wr_en | input | 1 | Control register write enable |
| wr_data | input | 8 | Control write value (bit 7 ignored) |
| rd_data | output | 8 | {uip, divider field, rate code} |
| update_o | output | 1 | Once-per-second update strobe |
| uip_o | output | 1 | Update-in-progress flag |
| periodic_o | output | 1 | Programmable periodic tick |

## Verification
The hardest case to reach from the ports is the chain's phase after long stretches the bench cannot watch directly: the midpoint restart under gappy ticks, and the grid alignment after a `set_hold` window that spans an expected update. The bench drives `tick_en` with a seeded random pattern while the chain restarts. It keeps its own tick count from the last observed update and checks that later updates and rate-15 periodic pulses land on exact multiples. Rate codes are drawn at random and checked against a computed period after resynchronising on the first pulse.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  localparam logic [2:0] DIV_RUN = 3'b010;

  // Maps a rate code to log2 of its period in ticks; 0 means off.
  function automatic logic [3:0] rate_shift(input logic [3:0] code);
    logic [3:0] s;
    case (code)
      4'd0: s = 4'd0;
      4'd1: s = 4'd7;
      4'd2: s = 4'd8;
      default: s = code - 4'd1;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [6:0] wr_bits,
  output logic [6:0] ctrl_q,
  output logic       run,
  output logic [3:0] rate
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= 7'h70;
    else if (wr_en) ctrl_q <= wr_bits;
  end

  assign run  = (ctrl_q[6:4] == DIV_RUN);
  assign rate = ctrl_q[3:0];
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] cnt_next,
  output logic             wrap
);
  localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] CNT_MID = {1'b1, {(DIV_W-1){1'b0}}};

  assign cnt_next = cnt + 1'b1;
  assign wrap     = tick_en && run && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= CNT_MID;
    else if (!run)    cnt <= CNT_MID;
    else if (tick_en) cnt <= cnt_next;
  end

  // R2
  held_at_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> (cnt == CNT_MID));
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
  import rtc_div_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic [3:0]       rate,
  input  logic [DIV_W-1:0] cnt_next,
  output logic             periodic_q
);
  logic [3:0]       shift;
  logic [DIV_W-1:0] mask;

  assign shift = rate_shift(rate);

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (i < int'(shift));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) periodic_q <= 1'b0;
    else        periodic_q <= tick_en && run && (shift != 4'd0) &&
                              ((cnt_next & mask) == '0);
  end

  // R7
  rate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) |=> !periodic_q);
  // R2
  held_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !periodic_q);
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int DIV_W    = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             set_hold,
  input  logic             wrap,
  input  logic [DIV_W-1:0] cnt,
  output logic             update_q,
  output logic             uip
);
  localparam logic [DIV_W-1:0] CNT_MAX   = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] UIP_START = CNT_MAX - DIV_W'(UIP_LEAD - 1);

  assign uip = run && !set_hold && (cnt >= UIP_START);

  always_ff @(posedge clk) begin
    if (!rst_n) update_q <= 1'b0;
    else        update_q <= wrap && !set_hold;
  end

  // R5
  uip_precedes_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |-> $past(uip));
  // R5
  uip_low_at_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |-> !uip);
  // R9
  set_masks_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |=> !update_q);
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |=> !update_q);
endmodule

// File: rtl/rtc_divchain_seq.sv
module rtc_divchain_seq #(
  parameter int DIV_W    = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       set_hold,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       update_o,
  output logic       uip_o,
  output logic       periodic_o
);
  logic [6:0]       ctrl_q;
  logic             run;
  logic [3:0]       rate;
  logic [DIV_W-1:0] cnt, cnt_next;
  logic             wrap;
  logic             wr_msb_unused;

  assign wr_msb_unused = wr_data[7];

  rtc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bits(wr_data[6:0]),
    .ctrl_q(ctrl_q), .run(run), .rate(rate)
  );

  rtc_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .cnt(cnt), .cnt_next(cnt_next), .wrap(wrap)
  );

  rtc_periodic #(.DIV_W(DIV_W)) u_per (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .rate(rate),
    .cnt_next(cnt_next), .periodic_q(periodic_o)
  );

  rtc_update_seq #(.DIV_W(DIV_W), .UIP_LEAD(UIP_LEAD)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .set_hold(set_hold), .wrap(wrap),
    .cnt(cnt), .update_q(update_o), .uip(uip_o)
  );

  assign rd_data = {uip_o, ctrl_q};

  // R10
  rd_flag_tracks_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_o) |-> rd_data[7]);
endmodule

// File: tb/tb_rtc_divchain_seq.sv
module tb_rtc_divchain_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tick_en = 1'b0, set_hold = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic update_o, uip_o, periodic_o;

  rtc_divchain_seq dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .set_hold(set_hold),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .update_o(update_o), .uip_o(uip_o), .periodic_o(periodic_o)
  );

  int n_chk = 0, n_bad = 0;
  int since = 0;
  bit done = 1'b0;

  function automatic int exp_period(input int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 1 << (code - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    logic t;
    t = tick_en;
    @(negedge clk);
    if (t) since++;
    if (update_o) since = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seen_u, seen_i, seen_p, ticks, run_len, p1, p2, rdbad, code, first, t0;
    void'($urandom(32'd4711));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(rd_data == 8'h70, "R1 rd_data", rd_data, 8'h70);
    chk(!update_o && !uip_o && !periodic_o, "R1 outputs", {update_o, uip_o, periodic_o}, 0);

    // R2 held divider: no activity even with a fast rate selected
    tick_en = 1'b1;
    wr(8'h7F);
    seen_u = 0; seen_i = 0; seen_p = 0;
    for (int i = 0; i < 2000; i++) begin
      step();
      seen_u += update_o; seen_i += uip_o; seen_p += periodic_o;
    end
    chk(seen_u + seen_i + seen_p == 0, "R2 held activity", seen_u + seen_i + seen_p, 0);
    chk(rd_data == 8'h7F, "R2 readback", rd_data, 8'h7F);

    // R3 release with gappy ticks; the write edge itself does not count
    tick_en = 1'b0;
    wr(8'h26);
    ticks = 0;
    for (int i = 0; i < 30000; i++) begin
      tick_en = ($urandom % 8) != 0;
      if (tick_en) ticks++;
      step();
      if (update_o) break;
    end
    chk(update_o && ticks == 16384, "R3 first update", ticks, 16384);
    tick_en = 1'b1;
    step();
    chk(!update_o, "R5 pulse width", update_o, 0);

    // R8/R4/R5/R10: rate 15, one full second, re-write run value mid-way
    wr(8'h2F);
    p1 = 0; p2 = 0; run_len = 0; rdbad = 0;
    for (int i = 0; i < 40000; i++) begin
      if (since == 5000) wr(8'h2F); else step();
      if (rd_data[7] != uip_o) rdbad++;
      if (periodic_o) begin
        if (p1 == 0) p1 = (update_o ? 32768 : since); else p2 = (update_o ? 32768 : since);
      end
      if (update_o) break;
      if (uip_o) run_len++; else run_len = 0;
    end
    chk(update_o, "R4 update seen", update_o, 1);
    chk(run_len == 8, "R5 uip window length", run_len, 8);
    chk(!uip_o, "R5 uip low at update", uip_o, 0);
    chk(p1 == 16384, "R8 mid-second tick", p1, 16384);
    chk(p2 == 32768, "R8 tick with update", p2, 32768);
    chk(rdbad == 0, "R10 rd bit7 tracks uip", rdbad, 0);

    // R6 directed then random rate codes
    for (int k = 0; k < 8; k++) begin
      code = (k == 0) ? 3 : (k == 1) ? 13 : (k == 2) ? 1 : 1 + ($urandom % 11);
      wr({4'b0010, code[3:0]});
      first = 0; t0 = 0;
      for (int i = 0; i < 20000; i++) begin
        step();
        if (periodic_o) begin
          if (first == 0) begin first = 1; t0 = i; end
          else begin t0 = i - t0; break; end
        end
      end
      chk(t0 == exp_period(code), "R6 period", t0, exp_period(code));
    end

    // R7 rate 0
    wr(8'h20);
    seen_p = 0;
    for (int i = 0; i < 500; i++) begin step(); seen_p += periodic_o; end
    chk(seen_p == 0, "R7 rate off", seen_p, 0);

    // R9/R10: set window spanning an update; write to bit 7 ignored
    set_hold = 1'b1;
    seen_u = 0; seen_i = 0;
    for (int i = 0; i < 33000; i++) begin
      if (i == 100) begin
        wr(8'hA6);
        chk(rd_data == 8'h26, "R10 bit7 write ignored", rd_data, 8'h26);
      end else step();
      seen_u += update_o; seen_i += uip_o;
    end
    chk(seen_u == 0 && seen_i == 0, "R9 masked", seen_u + seen_i, 0);
    ticks = since;
    set_hold = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      step();
      if (update_o) break;
      ticks++;
    end
    ticks++;
    chk(update_o && (ticks % 32768) == 0, "R9 grid kept", ticks % 32768, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule